// File: doc/BRIEF.md
# Terminal-Side Rail/NRZ Router for a Line Interface

This block sits between the terminal equipment and the line codec of a transmit/receive line interface. A mode input chooses between two terminal formats. In dual-rail format the codec is bypassed: separate positive and negative mark signals go straight to the line drivers and come straight from clock recovery. In single-line NRZ format, data goes to the line encoder and comes back from the line decoder. The router also disables the receive outputs on request and can replace transmit traffic with an all-ones alarm pattern. Two loopbacks are available. One sends transmitted marks back into the receive path. The other sends received data back out of the transmitter.

The whole block runs on one clock that stands for both the transmit clock and the recovered receive clock. Transmit data is captured on the rising edge. Receive data is launched on the falling edge. Every control input is active low except the mode input. Each output that can float has its own output-enable port, so high impedance can be seen at the ports.

Top module: `lit_termside`

## Requirements
- R1: With `nrz_mode_i` = 0 (rail mode), `term_pd_i`/`term_n_i` captured at a rising edge appear on `line_tx_p_o`/`line_tx_n_o` right after that edge, and `enc_d_o` stays 0.
- R2: With `nrz_mode_i` = 1 (NRZ mode), `term_pd_i` captured at a rising edge appears on `enc_d_o`. `term_n_i` has no effect, and `line_tx_p_o`/`line_tx_n_o` stay 0.
- R3: Receive data changes only at falling edges. In rail mode `rd_pd_o`/`rd_n_o` take `line_rx_p_i`/`line_rx_n_i`. In NRZ mode `rd_pd_o` takes `dec_d_i` and `rd_n_o` is 0.
- R4: In NRZ mode `rd_n_oe` and `rclk_n_oe` are 0. In rail mode with receive enabled, both are 1.
- R5: With `rx_dis_n_i` = 0, all four receive enables are 0 and `rd_pd_o`, `rd_n_o`, `rclk_o` and `rclk_n_o` are 0.
- R6: With `tx_ais_n_i` = 0 in NRZ mode, `enc_d_o` is 1 after every rising edge, whatever the terminal data.
- R7: With `tx_ais_n_i` = 0 in rail mode, marks alternate between the rails, starting with the positive rail at the first rising edge that sees the alarm. The two rails are never both 1. The alternation restarts when the alarm drops.
- R8: With `tx_lpbk_n_i` = 0, each falling edge loads the receive path from the transmit register: the positive rail (or NRZ bit) and, in rail mode, the negative rail. `line_rx_p_i`, `line_rx_n_i` and `dec_d_i` have no effect.
- R9: With `rx_lpbk_n_i` = 0, each rising edge loads the transmit register from the receive register, and `term_pd_i`/`term_n_i` have no effect.
- R10: With both loopbacks active, both paths run at once. The all-ones alarm overrides the data coming back through receive loopback.
- R11: While reset is asserted, all line, encoder and receive data outputs are 0. After `arst_n` rises, internal reset is released synchronously after `RST_STAGES` rising edges.
- R12: With receive enabled, `rclk_o` follows the clock. `rclk_n_o` is its inverse in rail mode and 0 in NRZ mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common transmit / recovered receive clock |
| arst_n | input | 1 | Asynchronous active-low reset |
| nrz_mode_i | input | 1 | 0 = dual-rail with codec bypass, 1 = NRZ through codec |
| rx_dis_n_i | input | 1 | Active-low receive output disable |
| tx_ais_n_i | input | 1 | Active-low all-ones alarm insertion |
| tx_lpbk_n_i | input | 1 | Active-low transmit-to-receive loopback |
| rx_lpbk_n_i | input | 1 | Active-low receive-to-transmit loopback |
| term_pd_i | input | 1 | Terminal positive rail, or NRZ data |
| term_n_i | input | 1 | Terminal negative rail (ignored in NRZ mode) |
| line_rx_p_i | input | 1 | Recovered positive rail from the line |
| line_rx_n_i | input | 1 | Recovered negative rail from the line |
| dec_d_i | input | 1 | NRZ data from the line decoder |
| line_tx_p_o | output | 1 | Positive rail to the line drivers (rail mode) |
| line_tx_n_o | output | 1 | Negative rail to the line drivers (rail mode) |
| enc_d_o | output | 1 | NRZ data to the line encoder (NRZ mode) |
| rd_pd_o | output | 1 | Receive positive rail, or NRZ data |
| rd_pd_oe | output | 1 | Output enable for `rd_pd_o` |
| rd_n_o | output | 1 | Receive negative rail |
| rd_n_oe | output | 1 | Output enable for `rd_n_o` |
| rclk_o | output | 1 | Receive clock |
| rclk_oe | output | 1 | Output enable for `rclk_o` |
| rclk_n_o | output | 1 | Inverted receive clock |
| rclk_n_oe | output | 1 | Output enable for `rclk_n_o` |

## Verification
The assertions check the register paths on every edge:
- alarm ones in NRZ mode, and one-rail-only alternation in rail mode;
- a quiet negative rail in NRZ mode;
- the transmit register loading from the receive register under receive loopback;
- the receive register loading from the transmit register under transmit loopback.

Only the bench scenarios can show the rest:
- that terminal and line inputs have no effect at the ports;
- the enable pattern across modes and receive disable;
- the starting rail and restart of the alarm alternation;
- the reset state;
- the two loopbacks combined with the alarm.

// File: rtl/lit_pkg.sv
package lit_pkg;
  // one mark per rail; in NRZ mode only pos carries data
  typedef struct packed {
    logic pos;
    logic neg;
  } rail_t;

  localparam logic MODE_RAIL = 1'b0;
  localparam logic MODE_NRZ  = 1'b1;
endpackage

// File: rtl/lit_rst_sync.sv
module lit_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] sh_q;
  logic [LAST:0] sh_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb sh_d = 1'b1;
    end else begin : g_many
      always_comb sh_d = {sh_q[LAST-1:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= sh_d;
  end

  assign rst_n_o = sh_q[LAST];
endmodule

// File: rtl/lit_tx_path.sv
module lit_tx_path
  import lit_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  nrz_mode,
  input  logic  ais_n,
  input  logic  rxlb_n,
  input  rail_t term_i,
  input  rail_t rx_i,
  output rail_t tx_o
);
  rail_t tx_q, tx_d, src;
  logic  ph_q, ph_d;

  always_comb begin
    // receive loopback picks the source before alarm insertion
    src  = rxlb_n ? term_i : rx_i;
    tx_d = src;
    ph_d = 1'b0;
    if (nrz_mode == MODE_NRZ) tx_d.neg = 1'b0;
    if (!ais_n) begin
      if (nrz_mode == MODE_NRZ) begin
        tx_d.pos = 1'b1;
        tx_d.neg = 1'b0;
      end else begin
        tx_d.pos = ~ph_q;
        tx_d.neg = ph_q;
        ph_d     = ~ph_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q <= '0;
      ph_q <= 1'b0;
    end else begin
      tx_q <= tx_d;
      ph_q <= ph_d;
    end
  end

  assign tx_o = tx_q;

  p_ais_nrz_ones_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && !ais_n && nrz_mode) |=> tx_q.pos);

  p_ais_one_rail_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && !ais_n && !nrz_mode) |=> (tx_q.pos ^ tx_q.neg));

  p_nrz_neg_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && nrz_mode) |=> !tx_q.neg);

  p_rxlb_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && !rxlb_n && ais_n) |=> (tx_q.pos == $past(rx_i.pos)));
endmodule

// File: rtl/lit_rx_path.sv
module lit_rx_path
  import lit_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  nrz_mode,
  input  logic  txlb_n,
  input  rail_t line_i,
  input  logic  dec_i,
  input  rail_t tx_i,
  output rail_t rx_o
);
  rail_t rx_q, rx_d;

  always_comb begin
    if (nrz_mode == MODE_NRZ) begin
      rx_d.pos = txlb_n ? dec_i : tx_i.pos;
      rx_d.neg = 1'b0;
    end else begin
      rx_d = txlb_n ? line_i : tx_i;
    end
  end

  // receive data is launched on the falling edge
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) rx_q <= '0;
    else        rx_q <= rx_d;
  end

  assign rx_o = rx_q;

  p_txlb_source_r8: assert property (@(negedge clk) disable iff (!rst_n)
    (rst_n && !txlb_n) |=> (rx_q.pos == $past(tx_i.pos)));

  p_nrz_rx_neg_quiet_r3: assert property (@(negedge clk) disable iff (!rst_n)
    (rst_n && nrz_mode) |=> !rx_q.neg);
endmodule

// File: rtl/lit_termside.sv
module lit_termside
  import lit_pkg::*;
#(
  parameter int RST_STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  input  logic nrz_mode_i,
  input  logic rx_dis_n_i,
  input  logic tx_ais_n_i,
  input  logic tx_lpbk_n_i,
  input  logic rx_lpbk_n_i,
  input  logic term_pd_i,
  input  logic term_n_i,
  input  logic line_rx_p_i,
  input  logic line_rx_n_i,
  input  logic dec_d_i,
  output logic line_tx_p_o,
  output logic line_tx_n_o,
  output logic enc_d_o,
  output logic rd_pd_o,
  output logic rd_pd_oe,
  output logic rd_n_o,
  output logic rd_n_oe,
  output logic rclk_o,
  output logic rclk_oe,
  output logic rclk_n_o,
  output logic rclk_n_oe
);
  logic  rst_n;
  rail_t term, line_rx, tx_r, rx_r;
  logic  rail_en;

  assign term    = '{pos: term_pd_i, neg: term_n_i};
  assign line_rx = '{pos: line_rx_p_i, neg: line_rx_n_i};

  lit_rst_sync #(.STAGES(RST_STAGES)) i_rst (
    .clk(clk), .arst_n(arst_n), .rst_n_o(rst_n)
  );

  lit_tx_path i_tx (
    .clk(clk), .rst_n(rst_n), .nrz_mode(nrz_mode_i), .ais_n(tx_ais_n_i),
    .rxlb_n(rx_lpbk_n_i), .term_i(term), .rx_i(rx_r), .tx_o(tx_r)
  );

  lit_rx_path i_rx (
    .clk(clk), .rst_n(rst_n), .nrz_mode(nrz_mode_i), .txlb_n(tx_lpbk_n_i),
    .line_i(line_rx), .dec_i(dec_d_i), .tx_i(tx_r), .rx_o(rx_r)
  );

  // transmit side: rails to the drivers in rail mode, NRZ bit to the encoder otherwise
  assign line_tx_p_o = (nrz_mode_i == MODE_RAIL) & tx_r.pos;
  assign line_tx_n_o = (nrz_mode_i == MODE_RAIL) & tx_r.neg;
  assign enc_d_o     = (nrz_mode_i == MODE_NRZ)  & tx_r.pos;

  // receive side enables
  assign rail_en   = rx_dis_n_i & (nrz_mode_i == MODE_RAIL);
  assign rd_pd_oe  = rx_dis_n_i;
  assign rclk_oe   = rx_dis_n_i;
  assign rd_n_oe   = rail_en;
  assign rclk_n_oe = rail_en;

  assign rd_pd_o  = rx_r.pos & rd_pd_oe;
  assign rd_n_o   = rx_r.neg & rd_n_oe;
  assign rclk_o   = clk & rclk_oe;
  assign rclk_n_o = ~clk & rclk_n_oe;

  p_dis_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_dis_n_i |-> (!rd_pd_o && !rd_n_o && !rclk_n_o));
endmodule

// File: tb/test_lit_termside.sv
module test_lit_termside;
  localparam int PERIOD = 10;
  localparam int NCYC   = 3000;

  logic clk = 1'b0;
  logic arst_n;
  logic nrz, rxdis_n, ais_n, txlb_n, rxlb_n, tp, tn, lp, ln, dd;
  logic line_tx_p_o, line_tx_n_o, enc_d_o, rd_pd_o, rd_pd_oe, rd_n_o, rd_n_oe;
  logic rclk_o, rclk_oe, rclk_n_o, rclk_n_oe;

  int checks = 0;
  int errors = 0;
  bit model_on = 1'b0;
  bit done = 1'b0;

  // bench model state
  logic m_tp = 1'b0, m_tn = 1'b0, m_ph = 1'b0, m_rp = 1'b0, m_rn = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  lit_termside i_lit_termside (
    .clk(clk), .arst_n(arst_n), .nrz_mode_i(nrz), .rx_dis_n_i(rxdis_n),
    .tx_ais_n_i(ais_n), .tx_lpbk_n_i(txlb_n), .rx_lpbk_n_i(rxlb_n),
    .term_pd_i(tp), .term_n_i(tn), .line_rx_p_i(lp), .line_rx_n_i(ln),
    .dec_d_i(dd), .line_tx_p_o(line_tx_p_o), .line_tx_n_o(line_tx_n_o),
    .enc_d_o(enc_d_o), .rd_pd_o(rd_pd_o), .rd_pd_oe(rd_pd_oe), .rd_n_o(rd_n_o),
    .rd_n_oe(rd_n_oe), .rclk_o(rclk_o), .rclk_oe(rclk_oe), .rclk_n_o(rclk_n_o),
    .rclk_n_oe(rclk_n_oe)
  );

  // transmit capture per R1/R2/R6/R7/R9
  always @(posedge clk) if (model_on) begin
    logic sp, sn;
    sp = rxlb_n ? tp : m_rp;
    sn = rxlb_n ? tn : m_rn;
    if (!ais_n) begin
      if (nrz) begin m_tp <= 1'b1; m_tn <= 1'b0; m_ph <= 1'b0; end
      else     begin m_tp <= ~m_ph; m_tn <= m_ph; m_ph <= ~m_ph; end
    end else begin
      m_tp <= sp; m_tn <= nrz ? 1'b0 : sn; m_ph <= 1'b0;
    end
  end

  // receive launch per R3/R8
  always @(negedge clk) if (model_on) begin
    if (nrz) begin m_rp <= txlb_n ? dd : m_tp; m_rn <= 1'b0; end
    else begin
      m_rp <= txlb_n ? lp : m_tp;
      m_rn <= txlb_n ? ln : m_tn;
    end
  end

  function automatic string tx_tag();
    if (!rxlb_n && !txlb_n) return "R10";
    if (!ais_n) return nrz ? "R6" : "R7";
    if (!rxlb_n) return "R9";
    return nrz ? "R2" : "R1";
  endfunction

  function automatic string rx_tag();
    if (!rxlb_n && !txlb_n) return "R10";
    return txlb_n ? "R3" : "R8";
  endfunction

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic check_low_phase();
    logic en, ren;
    en  = rxdis_n;
    ren = rxdis_n & ~nrz;
    chk(tx_tag(), "line_tx_p_o", line_tx_p_o, nrz ? 1'b0 : m_tp);
    chk(tx_tag(), "line_tx_n_o", line_tx_n_o, nrz ? 1'b0 : m_tn);
    chk(tx_tag(), "enc_d_o", enc_d_o, nrz ? m_tp : 1'b0);
    chk(rx_tag(), "rd_pd_o", rd_pd_o, en ? m_rp : 1'b0);
    chk(rx_tag(), "rd_n_o", rd_n_o, ren ? m_rn : 1'b0);
    chk(rxdis_n ? "R4" : "R5", "rd_pd_oe", rd_pd_oe, en);
    chk(rxdis_n ? "R4" : "R5", "rd_n_oe", rd_n_oe, ren);
    chk(rxdis_n ? "R4" : "R5", "rclk_oe", rclk_oe, en);
    chk(rxdis_n ? "R4" : "R5", "rclk_n_oe", rclk_n_oe, ren);
    chk("R12", "rclk_o low", rclk_o, 1'b0);
    chk("R12", "rclk_n_o low", rclk_n_o, ren);
  endtask

  task automatic set_in(input logic m, input logic dis, input logic ais,
                        input logic tlb, input logic rlb);
    nrz = m; rxdis_n = dis; ais_n = ais; txlb_n = tlb; rxlb_n = rlb;
    tp = 1'($urandom); tn = 1'($urandom); lp = 1'($urandom);
    ln = 1'($urandom); dd = 1'($urandom);
  endtask

  // one cycle: check clocks high, drive, check after falling edge
  task automatic cycle(input logic m, input logic dis, input logic ais,
                       input logic tlb, input logic rlb);
    @(posedge clk);
    #1;
    chk("R12", "rclk_o high", rclk_o, rxdis_n);
    chk("R12", "rclk_n_o high", rclk_n_o, 1'b0);
    #1;
    set_in(m, dis, ais, tlb, rlb);
    @(negedge clk);
    #3;
    check_low_phase();
  endtask

  initial begin
    void'($urandom(32'd4242));
    arst_n = 1'b0;
    nrz = 1'b0; rxdis_n = 1'b1; ais_n = 1'b1; txlb_n = 1'b0; rxlb_n = 1'b0;
    tp = 1'b1; tn = 1'b1; lp = 1'b1; ln = 1'b1; dd = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); #3;
    // R11: reset holds every data output low despite active inputs
    chk("R11", "line_tx_p_o", line_tx_p_o, 1'b0);
    chk("R11", "line_tx_n_o", line_tx_n_o, 1'b0);
    chk("R11", "enc_d_o", enc_d_o, 1'b0);
    chk("R11", "rd_pd_o", rd_pd_o, 1'b0);
    chk("R11", "rd_n_o", rd_n_o, 1'b0);
    // idle inputs, then release
    txlb_n = 1'b1; rxlb_n = 1'b1; tp = 1'b0; tn = 1'b0; lp = 1'b0; ln = 1'b0; dd = 1'b0;
    #1 arst_n = 1'b1;
    repeat (4) @(posedge clk);
    #2 model_on = 1'b1;
    // directed: rail mode alarm alternation, restart after a gap (R7)
    for (int i = 0; i < 6; i++) cycle(1'b0, 1'b1, 1'b0, 1'b1, 1'b1);
    for (int i = 0; i < 2; i++) cycle(1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
    for (int i = 0; i < 3; i++) cycle(1'b0, 1'b1, 1'b0, 1'b1, 1'b1);
    // directed: both loopbacks, with and without alarm (R10)
    for (int i = 0; i < 6; i++) cycle(1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 4; i++) cycle(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 4; i++) cycle(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    // directed: receive disabled in both modes (R5), NRZ mode (R2, R4)
    for (int i = 0; i < 3; i++) cycle(1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
    for (int i = 0; i < 3; i++) cycle(1'b1, 1'b0, 1'b1, 1'b1, 1'b1);
    for (int i = 0; i < 5; i++) cycle(1'b1, 1'b1, 1'b1, 1'b1, 1'b1);
    // constrained random: modes held in runs, controls biased inactive
    for (int i = 0; i < NCYC; i++) begin
      logic m;
      m = ((i / 64) % 2) == 1;
      cycle(m, ($urandom % 8) != 0, ($urandom % 5) != 0,
            ($urandom % 4) != 0, ($urandom % 4) != 0);
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule